// File: doc/BRIEF.md
# Byte-Lane Write Parity Checker

This block watches write beats headed for a synchronous SRAM array and flags any beat whose enabled byte lanes fail a parity test. Each lane is nine bits wide, eight data bits and one parity bit. The default build has four lanes (36 bits), and a two-lane build (18 bits) is chosen through a parameter. A strap input selects whether a healthy lane must hold even or odd parity across all nine bits. A second strap selects how late the fault is reported. In flow-through mode the report comes one cycle after the beat. In pipeline mode it comes one cycle later still, matching the extra output register of that mode.

The fault output models an open-drain pin. Its data value is fixed at 0, and an enable drives the line only while a fault is being reported. Outputs from several devices can therefore share one pull-up and read as a wired-OR of low-going faults.

Write data enters as a plain stream qualified by `wr_valid`. The checker accepts every beat on the cycle it is presented, so the interface has no ready signal and applies no back-pressure. Cycles with `wr_valid` low, such as reads or idle cycles, are never checked.

Top module: `wr_parity_guard`

## Requirements
- R1: With `even_sel` = 1, an enabled lane on a valid beat is faulty when the XOR of its nine bits is 1. Lane i occupies bits [9i+8:9i] of `wr_data`.
- R2: With `even_sel` = 0, an enabled lane on a valid beat is faulty when the XOR of its nine bits is 0.
- R3: A beat with `wr_valid` = 0 never produces a fault report, whatever its data.
- R4: Lane i takes part in the check only when `lane_en[i]` = 1. A lane with bad parity and its enable bit at 0 produces no report.
- R5: With `pipe_mode` = 0 (flow-through), a faulty beat sampled at clock edge N drives `err_oe` high from edge N until edge N+1.
- R6: With `pipe_mode` = 1 (pipeline), a faulty beat sampled at clock edge N drives `err_oe` high from edge N+1 until edge N+2.
- R7: Each faulty beat gives exactly one report cycle. Back-to-back faulty beats give back-to-back high cycles of `err_oe`, and a clean beat leaves `err_oe` low in its report slot.
- R8: `err_q` is always 0, and `err_oe` is 0 whenever no fault is being reported, so the line is released.
- R9: An active-low `rst_n` clears pending reports at once, including one still in flight in the pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Qualifies the current write beat |
| wr_data | input | 9*LANES | Write lanes, lane i at [9i+8:9i] |
| lane_en | input | LANES | Per-lane write enable, active high |
| even_sel | input | 1 | 1: even parity expected, 0: odd |
| pipe_mode | input | 1 | 1: pipeline latency, 0: flow-through latency |
| err_q | output | 1 | Open-drain data value, always 0 |
| err_oe | output | 1 | Drive enable: high while a fault is reported |

## Verification
The hardest case to reach from the ports is a pipeline-mode fault still held in the second stage when reset arrives. To create it, the bench presents a faulty beat in pipeline mode and drops reset on the very next half cycle, before the report can appear. It then checks that the slot stays empty.

Masked bad lanes and bad lanes on non-valid beats are also steered into the report slots deliberately. Since `err_oe` is observed every cycle, any report that should have been suppressed is caught.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic {
    RPT_FLOW = 1'b0,
    RPT_PIPE = 1'b1
  } rpt_mode_e;

  function automatic logic lane_xor(input logic [LANE_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/wpg_lane_check.sv
module wpg_lane_check
  import wpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_bits,
  input  logic              lane_on,
  input  logic              even_req,
  output logic              lane_fault
);
  logic odd_weight;

  always_comb begin
    odd_weight = lane_xor(lane_bits);
    lane_fault = lane_on & (even_req ? odd_weight : ~odd_weight);
  end

  // R4: a disabled lane never reports
  assert_masked_lane_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_on |-> !lane_fault);
endmodule

// File: rtl/wpg_report_pipe.sv
module wpg_report_pipe
  import wpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      beat_fault,
  input  rpt_mode_e mode,
  output logic      report
);
  localparam int unsigned DEPTH = 2;
  logic [DEPTH-1:0] stage;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= beat_fault;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[k] <= 1'b0;
          else        stage[k] <= stage[k-1];
        end
      end
    end
  endgenerate

  always_comb report = (mode == RPT_PIPE) ? stage[DEPTH-1] : stage[0];
endmodule

// File: rtl/wr_parity_guard.sv
module wr_parity_guard
  import wpg_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        lane_en,
  input  logic                    even_sel,
  input  logic                    pipe_mode,
  output logic                    err_q,
  output logic                    err_oe
);
  localparam int unsigned BUS_W = LANES * LANE_W;

  logic [LANES-1:0] lane_fault;
  logic             beat_fault;
  rpt_mode_e        mode;
  logic             report;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      wpg_lane_check u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_bits  (wr_data[i*LANE_W +: LANE_W]),
        .lane_on    (lane_en[i]),
        .even_req   (even_sel),
        .lane_fault (lane_fault[i])
      );
    end
  endgenerate

  always_comb begin
    beat_fault = wr_valid & (|lane_fault);
    mode       = pipe_mode ? RPT_PIPE : RPT_FLOW;
  end

  wpg_report_pipe u_rpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fault (beat_fault),
    .mode       (mode),
    .report     (report)
  );

  assign err_q  = 1'b0;
  assign err_oe = report;

  // cycles since reset, saturating; gates the latency checks
  logic [1:0] armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 2'd0;
    else if (armed != 2'd3) armed <= armed + 2'd1;
  end

  // R3: invalid beats never feed the reporter
  assert_invalid_beat_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !beat_fault);

  // R5: flow-through reports one edge after the beat
  assert_flow_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed >= 2'd1 && !pipe_mode) |-> (err_oe == $past(beat_fault)));

  // R6: pipeline reports two edges after the beat
  assert_pipe_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed >= 2'd2 && pipe_mode) |-> (err_oe == $past(beat_fault, 2)));

  // R8: the line is only driven when a fault was seen recently
  assert_release_when_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed >= 2'd2 && !$past(beat_fault) && !$past(beat_fault, 2)) |-> !err_oe);

  logic unused_w;
  assign unused_w = ^BUS_W;
endmodule

// File: tb/wr_parity_guard_tb.sv
module wr_parity_guard_tb;
  localparam int L = 4;
  localparam int W = 9 * L;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [L-1:0] lane_en = '0;
  logic         even_sel = 1'b1;
  logic         pipe_mode = 1'b0;
  logic         err_q, err_oe;

  int total = 0;
  int fails = 0;
  bit h1 = 0, h2 = 0;

  always #4 clk = ~clk;

  wr_parity_guard #(.LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .lane_en(lane_en), .even_sel(even_sel), .pipe_mode(pipe_mode),
    .err_q(err_q), .err_oe(err_oe)
  );

  function automatic logic [W-1:0] mk_beat(input logic [31:0] bytes,
                                           input logic [L-1:0] bad, input bit ev);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < L; i++) begin
      logic [7:0] b;
      logic p;
      b = bytes[8*i +: 8];
      p = ev ? ^b : ~^b;
      if (bad[i]) p = ~p;
      r[9*i +: 9] = {p, b};
    end
    return r;
  endfunction

  function automatic bit ref_fault(input bit v, input logic [W-1:0] d,
                                   input logic [L-1:0] en, input bit ev);
    bit f;
    f = 0;
    for (int i = 0; i < L; i++)
      if (en[i] && ((^d[9*i +: 9]) != (ev ? 1'b0 : 1'b1))) f = 1;
    return v && f;
  endfunction

  task automatic check(input string tag);
    bit exp;
    exp = pipe_mode ? h2 : h1;
    total++;
    if (err_oe !== exp) begin
      fails++;
      $display("FAIL %s err_oe actual=%b expected=%b", tag, err_oe, exp);
    end
    total++;
    if (err_q !== 1'b0) begin
      fails++;
      $display("FAIL R8 err_q actual=%b expected=0", err_q);
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] d, input logic [L-1:0] en,
                      input string tag);
    @(negedge clk);
    check(tag);
    wr_valid = v; wr_data = d; lane_en = en;
    @(posedge clk);
    h2 = h1;
    h1 = ref_fault(v, d, en, even_sel);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    check(tag);
    rst_n = 1'b0; wr_valid = 1'b0;
    h1 = 0; h2 = 0;
    #1;
    total++;
    if (err_oe !== 1'b0) begin
      fails++;
      $display("FAIL %s err_oe in reset actual=%b expected=0", tag, err_oe);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R8: reset state
    @(negedge clk);
    check("R8");
    rst_n = 1'b1;
    @(posedge clk);

    // flow-through, even parity
    pipe_mode = 1'b0; even_sel = 1'b1;
    step(1, mk_beat(32'hA5C3_0F81, 4'b0000, 1), 4'hF, "R1");
    step(1, mk_beat(32'h1234_5678, 4'b0100, 1), 4'hF, "R1");
    step(0, '0, '0, "R5");
    step(1, mk_beat(32'hDEAD_BEEF, 4'b0100, 1), 4'b1011, "R4");
    step(0, mk_beat(32'hCAFE_0001, 4'b1111, 1), 4'hF, "R3");
    step(1, mk_beat(32'h0000_0000, 4'b0001, 1), 4'hF, "R7");
    step(1, mk_beat(32'hFFFF_FFFF, 4'b1000, 1), 4'hF, "R7");
    step(1, mk_beat(32'h5555_AAAA, 4'b0000, 1), 4'hF, "R7");
    step(1, mk_beat(32'h0F0F_F0F0, 4'b0010, 1), 4'b0010, "R7");
    idle(3, "R8");

    // flow-through, odd parity
    even_sel = 1'b0;
    step(1, mk_beat(32'h1357_9BDF, 4'b0000, 0), 4'hF, "R2");
    step(1, mk_beat(32'h2468_ACE0, 4'b0001, 0), 4'hF, "R2");
    step(1, mk_beat(32'h2468_ACE0, 4'b0000, 1), 4'hF, "R2");
    idle(3, "R2");

    // pipeline mode
    do_reset("R9");
    pipe_mode = 1'b1; even_sel = 1'b1;
    step(1, mk_beat(32'h8000_0001, 4'b0010, 1), 4'hF, "R6");
    step(0, '0, '0, "R6");
    step(0, '0, '0, "R6");
    step(1, mk_beat(32'h7777_1111, 4'b1111, 1), 4'hF, "R7");
    step(1, mk_beat(32'h7777_1111, 4'b1000, 1), 4'b0111, "R4");
    step(1, mk_beat(32'h7777_1111, 4'b0001, 1), 4'hF, "R7");
    idle(3, "R6");

    // R9: fault in flight at reset
    step(1, mk_beat(32'h0101_0101, 4'b0100, 1), 4'hF, "R9");
    do_reset("R9");
    idle(3, "R9");

    // randomised beats in both modes and polarities
    for (int m = 0; m < 4; m++) begin
      do_reset("R9");
      pipe_mode = m[0];
      even_sel  = m[1];
      for (int k = 0; k < 150; k++)
        step($urandom_range(0, 3) != 0,
             mk_beat($urandom, L'($urandom), even_sel) ^ W'({$urandom, $urandom} & 64'h1),
             L'($urandom), pipe_mode ? "R6" : "R5");
      idle(3, "R8");
    end

    @(negedge clk);
    check("R8");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule